// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block paces a UART's oversampling. Each clock of its input is one unit of time. The sample period is programmed as an integer number of units plus a fraction counted in 1/255 steps. On most periods a sample tick fires after the integer count. An error accumulator advances by the fraction on every period, and on the periods where it wraps the block adds one extra unit. Over a long run the mean period therefore equals the programmed value. A second output, the bit tick, divides the sample ticks by 8 or 16, as the mode register selects.

Two 32-bit registers are written through a simple port that has byte enables. The divisor register holds the period. The mode register holds the oversampling select and a 4-bit transmit end-point field, which a neighbouring transmitter reads. Any write restarts the timing cleanly on the next clock. The block also presents the length of one bit time in clocks, for use by logic such as a turnaround-delay counter.

Top module: `frac_baud_gen`

## Requirements
- R1: Address 0 selects the divisor register. Its bits 31:8 are the integer period N and its bits 7:0 are the fraction f. With f = 0, sample ticks fire exactly every N clocks.
- R2: Counting periods from 1 after a restart, period j lasts N+1 clocks when floor(j·f'/255) > floor((j−1)·f'/255), and N clocks otherwise. f' is f modulo 255, so f = 255 behaves as 0.
- R3: An integer field of 0 or 1 behaves as 2, so two sample ticks never fall on consecutive clocks.
- R4: Address 1 selects the mode register. Its bit 30 set selects 16x oversampling and clear selects 8x, so 0x6EF71000 gives 16x and 0x26731000 gives 8x. The bit tick is a one-clock pulse that coincides with every 16th or 8th sample tick after a restart.
- R5: A write changes only the byte lanes whose enable bit is set (lane k covers bits 8k+7:8k). Mode bits 23:20 appear on `tx_endpt_o`. Clearing them with a lane-2 write that keeps bits 19:16 leaves every other mode bit and the oversampling unchanged.
- R6: In the clock after the edge that accepts a write, there is no sample tick. The first sample tick falls in clock N+1 after that edge. The fraction accumulator and the bit-tick count both restart.
- R7: `bit_period_o` equals the effective integer period multiplied by the current oversampling count.
- R8: Reset loads the divisor 0x00000200 and the mode 0x6EF71000 and holds both ticks low. Ticks then start as after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one period is one time unit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = divisor, 1 = mode |
| wr_be_i | input | 4 | Byte-lane write enables |
| wr_data_i | input | 32 | Write data |
| sample_tick_o | output | 1 | Oversampling tick, one clock wide |
| bit_tick_o | output | 1 | One pulse per 8 or 16 sample ticks |
| os16_o | output | 1 | 1 when 16x oversampling is selected |
| tx_endpt_o | output | 4 | Transmit end-point field of the mode register |
| mode_o | output | 32 | Current mode register contents |
| bit_period_o | output | 28 | Clocks per bit time (integer part) |

## Verification
Some properties are checked on every clock by the bound assertions:
- sample ticks never fall on consecutive clocks;
- every gap between ticks is N or N+1;
- each bit tick sits on a sample tick and lands exactly on the 8th or 16th one;
- a write silences the next clock;
- the end-point field holds still unless its lane is written.

Other behaviour can only be shown by the bench's scenarios, which compare every period against the floor formula:
- which particular periods are stretched, and that over 255 periods there are exactly f extra units;
- that f = 255 acts as zero;
- the clamp of small integers;
- that byte-lane writes leave the other fields alone;
- the exact position of the first tick after a write made partway through a period.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int OS_LO = 8;
  localparam int OS_HI = 16;
  localparam int SUB_W = $clog2(OS_HI);

  typedef enum logic {
    SEL_DIV  = 1'b0,
    SEL_MODE = 1'b1
  } reg_sel_e;

  localparam logic [31:0] MODE_X16 = 32'h6EF7_1000;
  localparam logic [31:0] MODE_X8  = 32'h2673_1000;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs import fbg_pkg::*; #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] RST_DIV  = 'h200,
  parameter logic [REG_W-1:0] RST_MODE = 'h6EF7_1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [REG_W/8-1:0] wr_be_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   div_q,
  output logic [REG_W-1:0]   mode_q,
  output logic               reload_q
);
  localparam int NB = REG_W / 8;

  logic div_hit;
  logic mode_hit;

  assign div_hit  = wr_en_i && (wr_addr_i == SEL_DIV);
  assign mode_hit = wr_en_i && (wr_addr_i == SEL_MODE);

  // one flop group per byte lane so unselected lanes keep their value
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q[b*8 +: 8]  <= RST_DIV[b*8 +: 8];
        mode_q[b*8 +: 8] <= RST_MODE[b*8 +: 8];
      end else begin
        if (div_hit && wr_be_i[b])  div_q[b*8 +: 8]  <= wr_data_i[b*8 +: 8];
        if (mode_hit && wr_be_i[b]) mode_q[b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end

  // any accepted write, and reset itself, restarts the timing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reload_q <= 1'b1;
    else         reload_q <= wr_en_i;
  end
endmodule

// File: rtl/fbg_period.sv
module fbg_period #(
  parameter int INT_W  = 24,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [INT_W-1:0]  int_raw_i,
  input  logic [FRAC_W-1:0] frac_raw_i,
  output logic [INT_W-1:0]  int_eff_o,
  output logic              tick_o
);
  localparam int DEN = (1 << FRAC_W) - 1;
  localparam int SW  = FRAC_W + 1;

  function automatic logic [INT_W-1:0] clamp_int(input logic [INT_W-1:0] v);
    return (v < INT_W'(2)) ? INT_W'(2) : v;
  endfunction

  function automatic logic [FRAC_W-1:0] fold_frac(input logic [FRAC_W-1:0] v);
    return (v == FRAC_W'(DEN)) ? '0 : v;
  endfunction

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_base;
  logic [FRAC_W-1:0] acc_nxt;
  logic [FRAC_W-1:0] frac_eff;
  logic [SW-1:0]     sum;
  logic              wrap;
  logic              load;

  assign int_eff_o = clamp_int(int_raw_i);
  assign frac_eff  = fold_frac(frac_raw_i);

  always_comb begin
    acc_base = reload_i ? '0 : acc_q;
    sum      = SW'(acc_base) + SW'(frac_eff);
    wrap     = (sum >= SW'(DEN));
    acc_nxt  = wrap ? FRAC_W'(sum - SW'(DEN)) : FRAC_W'(sum);
  end

  assign load   = reload_i || (cnt_q == '0);
  assign tick_o = (cnt_q == '0) && !reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (load) begin
      cnt_q <= int_eff_o - INT_W'(1) + INT_W'(wrap);
      acc_q <= acc_nxt;
    end else begin
      cnt_q <= cnt_q - INT_W'(1);
    end
  end
endmodule

// File: rtl/fbg_oversample.sv
module fbg_oversample import fbg_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  input  logic tick_i,
  input  logic os16_i,
  output logic bit_tick_o
);
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] last;

  assign last       = os16_i ? SUB_W'(OS_HI - 1) : SUB_W'(OS_LO - 1);
  assign bit_tick_o = tick_i && (sub_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sub_q <= '0;
    else if (reload_i) sub_q <= '0;
    else if (tick_i)   sub_q <= (sub_q == last) ? '0 : sub_q + SUB_W'(1);
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen import fbg_pkg::*; #(
  parameter int INT_W      = 24,
  parameter int FRAC_W     = 8,
  parameter int OS_SEL_BIT = 30,
  parameter int EP_LSB     = 20,
  parameter int EP_W       = 4,
  parameter logic [INT_W+FRAC_W-1:0] RST_DIV  = 'h200,
  parameter logic [INT_W+FRAC_W-1:0] RST_MODE = 'h6EF7_1000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic                            wr_addr_i,
  input  logic [(INT_W+FRAC_W)/8-1:0]     wr_be_i,
  input  logic [INT_W+FRAC_W-1:0]         wr_data_i,
  output logic                            sample_tick_o,
  output logic                            bit_tick_o,
  output logic                            os16_o,
  output logic [EP_W-1:0]                 tx_endpt_o,
  output logic [INT_W+FRAC_W-1:0]         mode_o,
  output logic [INT_W+$clog2(OS_HI)-1:0]  bit_period_o
);
  localparam int REG_W = INT_W + FRAC_W;
  localparam int NB    = REG_W / 8;
  localparam int BP_W  = INT_W + $clog2(OS_HI);

  function automatic logic [BP_W-1:0] bit_span(input logic [INT_W-1:0] n, input logic x16);
    return x16 ? (BP_W'(n) << $clog2(OS_HI)) : (BP_W'(n) << $clog2(OS_LO));
  endfunction

  logic [REG_W-1:0] div_q;
  logic [REG_W-1:0] mode_q;
  logic             reload_q;
  logic [INT_W-1:0] int_eff;
  logic             tick;

  fbg_regs #(
    .REG_W    (REG_W),
    .RST_DIV  (RST_DIV),
    .RST_MODE (RST_MODE)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_be_i   (wr_be_i),
    .wr_data_i (wr_data_i),
    .div_q     (div_q),
    .mode_q    (mode_q),
    .reload_q  (reload_q)
  );

  fbg_period #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
  ) u_period (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload_q),
    .int_raw_i  (div_q[REG_W-1:FRAC_W]),
    .frac_raw_i (div_q[FRAC_W-1:0]),
    .int_eff_o  (int_eff),
    .tick_o     (tick)
  );

  fbg_oversample u_os (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reload_i   (reload_q),
    .tick_i     (tick),
    .os16_i     (os16_o),
    .bit_tick_o (bit_tick_o)
  );

  assign sample_tick_o = tick;
  assign os16_o        = mode_q[OS_SEL_BIT];
  assign tx_endpt_o    = mode_q[EP_LSB +: EP_W];
  assign mode_o        = mode_q;
  assign bit_period_o  = bit_span(int_eff, os16_o);
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk import fbg_pkg::*; #(
  parameter int INT_W   = 24,
  parameter int NB      = 4,
  parameter int EP_W    = 4,
  parameter int EP_LANE = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_addr_i,
  input logic [NB-1:0]    wr_be_i,
  input logic             sample_tick_o,
  input logic             bit_tick_o,
  input logic             os16_o,
  input logic [EP_W-1:0]  tx_endpt_o,
  input logic             reload_i,
  input logic [INT_W-1:0] int_eff_i
);
  localparam int GW = INT_W + 1;

  logic [GW-1:0]    gap_q;
  logic [GW-1:0]    n_ext;
  logic             armed_q;
  logic [SUB_W:0]   scnt_q;
  logic [SUB_W:0]   os_m1;

  assign n_ext = GW'(int_eff_i);
  assign os_m1 = os16_o ? (SUB_W+1)'(OS_HI - 1) : (SUB_W+1)'(OS_LO - 1);

  // clocks since the previous sample tick, valid once a tick follows a restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
      scnt_q  <= '0;
    end else begin
      if (reload_i) begin
        gap_q   <= '0;
        armed_q <= 1'b0;
      end else if (sample_tick_o) begin
        gap_q   <= GW'(1);
        armed_q <= 1'b1;
      end else begin
        gap_q <= gap_q + GW'(1);
      end
      if (reload_i || bit_tick_o)  scnt_q <= '0;
      else if (sample_tick_o)      scnt_q <= scnt_q + (SUB_W+1)'(1);
    end
  end

  p_no_back_to_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |=> !sample_tick_o);

  p_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_tick_o && armed_q) |-> (gap_q == n_ext || gap_q == n_ext + GW'(1)));

  p_bit_on_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  p_bit_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (scnt_q == os_m1));

  p_bit_due_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_tick_o && scnt_q == os_m1) |-> bit_tick_o);

  p_quiet_after_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !sample_tick_o);

  p_endpt_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i && wr_be_i[EP_LANE]) |=> $stable(tx_endpt_o));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .INT_W   (INT_W),
  .NB      (NB),
  .EP_W    (EP_W),
  .EP_LANE (EP_LSB / 8)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_be_i       (wr_be_i),
  .sample_tick_o (sample_tick_o),
  .bit_tick_o    (bit_tick_o),
  .os16_o        (os16_o),
  .tx_endpt_o    (tx_endpt_o),
  .reload_i      (reload_q),
  .int_eff_i     (int_eff)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        sample_tick;
  logic        bit_tick;
  logic        os16;
  logic [3:0]  tx_endpt;
  logic [31:0] mode;
  logic [27:0] bit_period;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  frac_baud_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_be_i       (wr_be),
    .wr_data_i     (wr_data),
    .sample_tick_o (sample_tick),
    .bit_tick_o    (bit_tick),
    .os16_o        (os16),
    .tx_endpt_o    (tx_endpt),
    .mode_o        (mode),
    .bit_period_o  (bit_period)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called in the first clock after a restart; checks nper periods
  task automatic run(input int n, input int f, input int os, input int nper, input string req);
    int c = 1;
    int j = 1;
    int fe = (f == 255) ? 0 : f;
    int nxt = 1 + n;
    int ext;
    string r;
    while (j <= nper) begin
      if (bit_tick && !sample_tick) chk(1'b0, "R4", "bit tick without sample tick", 1, 0);
      if (sample_tick || c == nxt) begin
        r = (j == 1) ? "R6" : req;
        chk(sample_tick && c == nxt, r, "sample tick cycle", sample_tick ? c : -1, nxt);
        if (sample_tick)
          chk(bit_tick == ((j % os) == 0), "R4", "bit tick position", int'(bit_tick), int'((j % os) == 0));
        ext = ((j + 1) * fe) / 255 - (j * fe) / 255;
        nxt = (sample_tick ? c : nxt) + n + ext;
        j++;
      end
      @(negedge clk);
      c++;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!sample_tick && !bit_tick, "R8", "ticks in reset", int'(sample_tick), 0);
    chk(mode == 32'h6EF7_1000, "R8", "mode reset", int'(mode), 32'h6EF7_1000);
    chk(os16 == 1'b1, "R8", "os16 reset", int'(os16), 1);
    chk(tx_endpt == 4'hF, "R8", "endpoint reset", int'(tx_endpt), 15);
    chk(bit_period == 28'd32, "R8", "bit period reset", int'(bit_period), 32);
    rst_n = 1'b1;
    run(2, 0, 16, 20, "R8");
  endtask

  task automatic t_integer_16x;
    wr(1'b0, 4'hF, 32'h0000_0400);
    chk(bit_period == 28'd64, "R7", "bit period 4x16", int'(bit_period), 64);
    run(4, 0, 16, 40, "R1");
  endtask

  task automatic t_fraction_8x;
    wr(1'b1, 4'hF, 32'h2673_1000);
    wr(1'b0, 4'hF, 32'h0000_0364);
    chk(os16 == 1'b0, "R4", "8x select", int'(os16), 0);
    chk(bit_period == 28'd24, "R7", "bit period 3x8", int'(bit_period), 24);
    run(3, 100, 8, 60, "R2");
  endtask

  task automatic t_lane_frac;
    wr(1'b0, 4'b0001, 32'hFFFF_FFC8);
    chk(bit_period == 28'd24, "R5", "integer kept after lane-0 write", int'(bit_period), 24);
    run(3, 200, 8, 40, "R5");
  endtask

  task automatic t_fraction_full;
    wr(1'b0, 4'hF, 32'h0000_03FE);
    run(3, 254, 8, 255, "R2");
    wr(1'b0, 4'hF, 32'h0000_05FF);
    run(5, 255, 8, 20, "R2");
  endtask

  task automatic t_clamp;
    wr(1'b0, 4'hF, 32'h0000_0000);
    chk(bit_period == 28'd16, "R7", "bit period clamped 2x8", int'(bit_period), 16);
    run(2, 0, 8, 24, "R3");
    wr(1'b0, 4'hF, 32'h0000_0196);
    run(2, 150, 8, 30, "R3");
  endtask

  task automatic t_endpoint;
    wr(1'b1, 4'hF, 32'h6EF7_1000);
    wr(1'b1, 4'b0100, 32'h0007_0000);
    chk(mode == 32'h6E07_1000, "R5", "mode after endpoint clear", int'(mode), 32'h6E07_1000);
    chk(tx_endpt == 4'h0, "R5", "endpoint cleared", int'(tx_endpt), 0);
    chk(os16 == 1'b1, "R5", "oversampling kept", int'(os16), 1);
    run(2, 150, 16, 32, "R5");
  endtask

  task automatic t_midperiod;
    wr(1'b0, 4'hF, 32'h0000_0A00);
    run(10, 0, 16, 3, "R1");
    repeat (4) @(negedge clk);
    wr(1'b0, 4'hF, 32'h0000_0600);
    run(6, 0, 16, 20, "R6");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_be = '0; wr_data = '0;
    t_reset();
    t_integer_16x();
    t_fraction_8x();
    t_lane_frac();
    t_fraction_full();
    t_clamp();
    t_endpoint();
    t_midperiod();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL R6 watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule